// File: doc/BRIEF.md
# LCD Contrast PWM and Pin Function Select

This block drives two liquid-crystal contrast lines with pulse-width-modulated waveforms whose repetition rate is 1 kHz. The rate is derived from the system clock by one shared period counter. Each contrast channel takes its duty from its own packed field of a 16-bit duty register. The two fields have different widths: a 5-bit field for the first channel and a 3-bit field for the second.

Each contrast pin is shared with other functions, and a 16-bit mode register picks one source per pin. The second pin can carry the slow-down clock-control request instead of its contrast wave. Either pin can fall back to a general-purpose data bit. A separate speaker path can fold an external speaker input into the internal speaker control signal by exclusive-or.

Both registers come in as plain inputs. Register access and the slow-down policy are handled elsewhere.

Top module: `lcd_contrast_pinmux`

## Requirements
- R1: While reset is held, and for the whole first PWM period after it is released, both contrast waves are low, whatever value is on the duty input.
- R2: Each contrast wave repeats every TICKS = CLK_HZ/PWM_HZ clock cycles. When its duty is nonzero, the high time starts at the first cycle of a period, and the wave is low in the last cycle of every period.
- R3: Channel 1 takes its duty N from bits 12:8 of the duty register, and its high time per period is ceil(N*TICKS/32) cycles.
- R4: Channel 2 takes its duty N from bits 15:13 of the duty register, and its high time per period is ceil(N*TICKS/8) cycles. The two channels are independent of each other.
- R5: A duty field of 0 holds its wave low for the whole period.
- R6: A duty written in the middle of a period leaves the rest of that period unchanged and takes effect from the next period boundary.
- R7: When mode bit 14 is 1, pin 2 carries the slow-down request input, regardless of mode bit 9 and of the GPIO data.
- R8: When mode bit 14 is 0, pin 2 carries the channel 2 wave if mode bit 9 is 1, and GPIO data bit 1 if mode bit 9 is 0.
- R9: Pin 1 carries the channel 1 wave only when mode bit 14 is 0 and mode bit 8 is 1. Otherwise it carries GPIO data bit 0.
- R10: When mode bit 6 is 1, the speaker output equals the speaker pin input XOR the speaker control. When mode bit 6 is 0, the speaker output equals the speaker control alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_reg_i | input | 16 | Pin-function mode register |
| duty_reg_i | input | 16 | Packed duty fields for both channels |
| slow_req_i | input | 1 | Slow-down clock-control request |
| gpio_i | input | 2 | GPIO data: bit 0 for pin 1, bit 1 for pin 2 |
| spk_ctl_i | input | 1 | Internal speaker control |
| spk_pin_i | input | 1 | External speaker input |
| pin_c1_o | output | 1 | Pin 1: contrast 1 or GPIO |
| pin_c2_o | output | 1 | Pin 2: contrast 2, slow-down or GPIO |
| spk_o | output | 1 | Speaker result |

## Verification
The bench builds the block with CLK_HZ set to 60000 and PWM_HZ set to 1000, which gives a 60-cycle period. A whole sequence of duty settings therefore fits in a few thousand cycles. A period of 60 is not a multiple of 32 or 8, so most duty values fall on a rounded-up boundary, and the ceiling in the high-time rule gets tested for both field widths. The bench changes the duty in the middle of a period, so every change also exercises the deferred update.

// File: rtl/lcdc_pkg.sv
// Shared constants and helpers for the LCD contrast block.
// Assumes 16-bit mode and duty registers; bit positions are fixed by the
// surrounding register decode.
package lcdc_pkg;

    localparam int REG_W        = 16;
    localparam int MODE_SLOW_BIT = 14;
    localparam int MODE_C2_BIT   = 9;
    localparam int MODE_C1_BIT   = 8;
    localparam int MODE_SPK_BIT  = 6;

    typedef enum logic [1:0] {
        SRC_GPIO = 2'd0,
        SRC_PWM  = 2'd1,
        SRC_SLOW = 2'd2
    } pin_src_e;

    typedef struct packed {
        logic slow_sel;
        logic c2_en;
        logic c1_en;
        logic spk_in_en;
    } pin_mode_t;

    // Pick the level a pin carries for a given source.
    function automatic logic pin_pick(pin_src_e src, logic pwm, logic slow, logic gp);
        logic v;
        unique case (src)
            SRC_PWM:  v = pwm;
            SRC_SLOW: v = slow;
            default:  v = gp;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/lcdc_period_ctr.sv
// Free-running period counter shared by all contrast channels.
// Counts 0 .. TICKS-1 and flags the last cycle of each period.
// Assumes TICKS >= 2.
module lcdc_period_ctr #(
    parameter int TICKS = 50000,
    parameter int CW    = $clog2(TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);

    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign wrap_o = (cnt_q == LAST);
    assign cnt_o  = cnt_q;

    // Advance the phase, returning to zero after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wrap_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + CW'(1);
    end

    // R2
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |=> (cnt_o == $past(cnt_o) + CW'(1)));

endmodule

// File: rtl/lcdc_pwm_chan.sv
// One contrast PWM channel. Latches its duty at each period boundary and
// drives a registered wave that is high while phase*2^W < duty*TICKS.
// Assumes cnt_i/wrap_i come from the shared period counter.
module lcdc_pwm_chan #(
    parameter int W     = 5,
    parameter int TICKS = 50000,
    parameter int CW    = $clog2(TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          wrap_i,
    input  logic [W-1:0]  duty_i,
    output logic          pwm_o
);

    localparam int PW = CW + W;
    localparam logic [PW-1:0] TICKS_V = PW'(TICKS);

    logic [W-1:0]  duty_q;
    logic [PW-1:0] phase_sc;
    logic [PW-1:0] thresh;
    logic          hi_next;
    logic          pwm_q;

    assign phase_sc = {cnt_i, {W{1'b0}}};
    assign thresh   = PW'(duty_q) * TICKS_V;
    assign hi_next  = (phase_sc < thresh);
    assign pwm_o    = pwm_q;

    // Take a new duty only at the period boundary; register the wave.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
            pwm_q  <= 1'b0;
        end else begin
            if (wrap_i) duty_q <= duty_i;
            pwm_q <= hi_next;
        end
    end

    // R6
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(duty_q));

    // R5
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |=> !pwm_o);

    // R2
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0 && duty_q != '0) |=> pwm_o);

    // R2
    last_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> !pwm_o);

endmodule

// File: rtl/lcdc_pin_sel.sv
// Pin-function selection for the two shared contrast pins and the speaker
// path. Purely combinational; mode bits are already decoded by the top.
module lcdc_pin_sel
    import lcdc_pkg::*;
(
    input  pin_mode_t mode_i,
    input  logic      pwm1_i,
    input  logic      pwm2_i,
    input  logic      slow_i,
    input  logic [1:0] gpio_i,
    input  logic      spk_ctl_i,
    input  logic      spk_pin_i,
    output logic      pin1_o,
    output logic      pin2_o,
    output logic      spk_o
);

    pin_src_e src1;
    pin_src_e src2;

    // Decide which function owns each pin; slow-down outranks contrast.
    always_comb begin
        if (mode_i.slow_sel)   src2 = SRC_SLOW;
        else if (mode_i.c2_en) src2 = SRC_PWM;
        else                   src2 = SRC_GPIO;
        src1 = (!mode_i.slow_sel && mode_i.c1_en) ? SRC_PWM : SRC_GPIO;
    end

    // Route the chosen sources to the pins and fold in the speaker input.
    always_comb begin
        pin1_o = pin_pick(src1, pwm1_i, 1'b0, gpio_i[0]);
        pin2_o = pin_pick(src2, pwm2_i, slow_i, gpio_i[1]);
        spk_o  = spk_ctl_i ^ (mode_i.spk_in_en & spk_pin_i);
    end

endmodule

// File: rtl/lcd_contrast_pinmux.sv
// Top of the LCD contrast block: a shared period counter, two PWM channels
// with packed duty fields of different widths, and the pin-function select.
// Assumes the duty fields sit at the top of the duty register, channel 2
// highest.
module lcd_contrast_pinmux
    import lcdc_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int PWM_HZ = 1000,
    parameter int C1_W   = 5,
    parameter int C2_W   = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] mode_reg_i,
    input  logic [15:0] duty_reg_i,
    input  logic        slow_req_i,
    input  logic [1:0]  gpio_i,
    input  logic        spk_ctl_i,
    input  logic        spk_pin_i,
    output logic        pin_c1_o,
    output logic        pin_c2_o,
    output logic        spk_o
);

    localparam int TICKS = CLK_HZ / PWM_HZ;
    localparam int CW    = $clog2(TICKS);
    localparam int C2_LO = REG_W - C2_W;
    localparam int C1_LO = C2_LO - C1_W;
    localparam logic [15:0] DUTY_USED = ({16{1'b1}} >> C1_LO) << C1_LO;
    localparam logic [15:0] MODE_USED = (16'd1 << MODE_SLOW_BIT) | (16'd1 << MODE_C2_BIT)
                                      | (16'd1 << MODE_C1_BIT) | (16'd1 << MODE_SPK_BIT);

    logic [CW-1:0] cnt;
    logic          wrap;
    logic [1:0]    pwm;
    pin_mode_t     pmode;
    logic          unused_cfg;

    assign unused_cfg = ^{duty_reg_i & ~DUTY_USED, mode_reg_i & ~MODE_USED};

    // Decode the mode register bits that steer the pins.
    always_comb begin
        pmode.slow_sel  = mode_reg_i[MODE_SLOW_BIT];
        pmode.c2_en     = mode_reg_i[MODE_C2_BIT];
        pmode.c1_en     = mode_reg_i[MODE_C1_BIT];
        pmode.spk_in_en = mode_reg_i[MODE_SPK_BIT];
    end

    lcdc_period_ctr #(.TICKS(TICKS), .CW(CW)) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    for (genvar g = 0; g < 2; g++) begin : g_chan
        localparam int W  = (g == 0) ? C1_W  : C2_W;
        localparam int LO = (g == 0) ? C1_LO : C2_LO;
        lcdc_pwm_chan #(.W(W), .TICKS(TICKS), .CW(CW)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_i  (cnt),
            .wrap_i (wrap),
            .duty_i (duty_reg_i[LO +: W]),
            .pwm_o  (pwm[g])
        );
    end

    lcdc_pin_sel u_sel (
        .mode_i    (pmode),
        .pwm1_i    (pwm[0]),
        .pwm2_i    (pwm[1]),
        .slow_i    (slow_req_i),
        .gpio_i    (gpio_i),
        .spk_ctl_i (spk_ctl_i),
        .spk_pin_i (spk_pin_i),
        .pin1_o    (pin_c1_o),
        .pin2_o    (pin_c2_o),
        .spk_o     (spk_o)
    );

    // R7
    pin2_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_reg_i[MODE_SLOW_BIT] |-> (pin_c2_o == slow_req_i));

    // R8
    pin2_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_reg_i[MODE_SLOW_BIT] && !mode_reg_i[MODE_C2_BIT]) |-> (pin_c2_o == gpio_i[1]));

    // R9
    pin1_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_reg_i[MODE_SLOW_BIT] |-> (pin_c1_o == gpio_i[0]));

    // R10
    spk_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_reg_i[MODE_SPK_BIT] |-> (spk_o == spk_ctl_i));

endmodule

// File: tb/lcd_contrast_pinmux_tb.sv
module lcd_contrast_pinmux_tb;

    localparam int CLK_HZ = 60_000;
    localparam int PWM_HZ = 1000;
    localparam int T      = CLK_HZ / PWM_HZ;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mode_r;
    logic [15:0] duty_r;
    logic        slow_r;
    logic [1:0]  gpio_r;
    logic        spk_ctl_r;
    logic        spk_pin_r;
    logic        pin1;
    logic        pin2;
    logic        spk;

    int ecnt  = 0;
    int total = 0;
    int bad   = 0;

    typedef struct {
        int    h1;
        int    h2;
        string tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

    lcd_contrast_pinmux #(.CLK_HZ(CLK_HZ), .PWM_HZ(PWM_HZ), .C1_W(5), .C2_W(3)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_reg_i (mode_r),
        .duty_reg_i (duty_r),
        .slow_req_i (slow_r),
        .gpio_i     (gpio_r),
        .spk_ctl_i  (spk_ctl_r),
        .spk_pin_i  (spk_pin_r),
        .pin_c1_o   (pin1),
        .pin_c2_o   (pin2),
        .spk_o      (spk)
    );

    task automatic chk_int(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int hi_len(int n, int w);
        return (n * T + (1 << w) - 1) / (1 << w);
    endfunction

    // Driver side: queue expected high times for n periods of one setting.
    task automatic push_win(int d1, int d2, int n, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.h1 = hi_len(d1, 5);
            e.h2 = hi_len(d2, 3);
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    // Write a duty in mid-period; it applies from the next period (R6).
    task automatic seg(int d1, int d2, int n, string tag);
        duty_r = {3'(d2), 5'(d1), 8'hA5};
        push_win(d1, d2, n, tag);
        repeat (n * T) @(negedge clk);
    endtask

    // Monitor: measure each period on both pins and compare with the queue.
    initial begin
        int  h1 = 0;
        int  h2 = 0;
        logic f1 = 1'b0;
        logic f2 = 1'b0;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && ecnt >= 1) begin
                int ph;
                ph = (ecnt - 1) % T;
                if (ph == 0) begin
                    h1 = 0; h2 = 0; f1 = pin1; f2 = pin2;
                end
                h1 += int'(pin1);
                h2 += int'(pin2);
                if (ph == T - 1 && q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    chk_int({e.tag, " R3 ch1 high time"}, h1, e.h1);
                    chk_int({e.tag, " R4 ch2 high time"}, h2, e.h2);
                    chk_int({e.tag, " R2 ch1 starts high"}, int'(f1), int'(e.h1 > 0));
                    chk_int({e.tag, " R2 ch2 starts high"}, int'(f2), int'(e.h2 > 0));
                end
            end
        end
    end

    task automatic pins(logic [15:0] m, logic s, logic [1:0] g);
        @(negedge clk);
        mode_r = m; slow_r = s; gpio_r = g;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        mode_r = 16'h0300; duty_r = {3'd7, 5'd31, 8'hA5};
        slow_r = 1'b1; gpio_r = 2'b00; spk_ctl_r = 1'b0; spk_pin_r = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk_int("R1 pin1 low in reset", int'(pin1), 0);
        chk_int("R1 pin2 low in reset", int'(pin2), 0);
        // R1: first period stays low though the duty input is full scale
        push_win(0, 0, 1, "R1 first period");
        @(negedge clk);
        rst_n = 1'b1;
        while (ecnt != T / 2 + 1) @(negedge clk);
        seg(31, 7, 2, "R3/R4 max");
        seg(1, 1, 2, "R3/R4 min");
        seg(16, 4, 2, "R6 change");
        seg(5, 3, 1, "R3/R4 rounded");
        seg(0, 0, 2, "R5 both zero");
        seg(0, 5, 1, "R5 ch1 zero");
        seg(0, 0, 1, "R5 idle");
        while (q.size() != 0) @(negedge clk);

        // R7: slow-down owns pin 2; R9: pin 1 falls back to GPIO
        pins(16'h4300, 1'b1, 2'b01);
        chk_int("R7 pin2 slow high", int'(pin2), 1);
        chk_int("R9 pin1 gpio with slow mode", int'(pin1), 1);
        pins(16'h4300, 1'b0, 2'b00);
        chk_int("R7 pin2 slow low", int'(pin2), 0);
        chk_int("R9 pin1 gpio low", int'(pin1), 0);
        pins(16'h4000, 1'b0, 2'b10);
        chk_int("R7 pin2 ignores gpio", int'(pin2), 0);
        pins(16'h4000, 1'b1, 2'b00);
        chk_int("R7 pin2 slow without bit9", int'(pin2), 1);
        // R8: pin 2 contrast (duty 0 -> low) or GPIO
        pins(16'h0200, 1'b1, 2'b11);
        chk_int("R8 pin2 contrast selected", int'(pin2), 0);
        chk_int("R9 pin1 gpio when bit8 clear", int'(pin1), 1);
        pins(16'h0000, 1'b1, 2'b10);
        chk_int("R8 pin2 gpio high", int'(pin2), 1);
        pins(16'h0000, 1'b1, 2'b00);
        chk_int("R8 pin2 gpio low", int'(pin2), 0);
        pins(16'h0100, 1'b0, 2'b01);
        chk_int("R9 pin1 contrast selected", int'(pin1), 0);

        // R10: speaker exclusive-or path
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            mode_r = 16'h0040; spk_ctl_r = k[1]; spk_pin_r = k[0];
            #1;
            chk_int("R10 spk xor", int'(spk), int'(k[1] ^ k[0]));
        end
        @(negedge clk);
        mode_r = 16'h0000; spk_ctl_r = 1'b1; spk_pin_r = 1'b1;
        #1;
        chk_int("R10 spk pin ignored high", int'(spk), 1);
        @(negedge clk);
        spk_ctl_r = 1'b0;
        #1;
        chk_int("R10 spk pin ignored low", int'(spk), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule